// File: doc/BRIEF.md
# Center-Aligned PWM Timer with Shadowed Phase and Compares

The block is a center-aligned PWM timer. Its counter climbs from zero to a fixed peak value and then falls back to zero, so one switching period lasts twice the peak count. A duty compare sets the output edges: the output rises on the climb and falls on the descent. This gives a pulse that is symmetric about the peak. A second event compare raises a one-cycle interrupt request. It does so only while the counter climbs, so a control routine can be scheduled at a fixed point before the peak.

Software writes the duty compare, the event compare and a phase offset through a small register port. Each write lands in a shadow copy and reaches the active copy only at a load event. The load event is either the counter at zero or the counter at its peak. It can be moved to the peak so that a freshly computed value acts half a period sooner. A phase write acts once, at the next load event: the counter jumps ahead by the written number of counts in its current direction. Single-cycle strobes mark the zero and peak points.

Top module: `pwm_updown`

## Requirements
- R1: The counter steps by one each cycle from 0 up to PERIOD (default 600) and back to 0, so a full period is 2*PERIOD cycles. `zero_o` is high in each cycle the count is 0 and `peak_o` is high in each cycle it equals PERIOD. Outside the reset stretch, each is a single-cycle pulse.
- R2: `pwm_o` goes high in the cycle after the count equals the active duty compare while climbing. It goes low in the cycle after the count equals it while falling.
- R3: `irq_o` is high for exactly the one cycle in which the count equals the active event compare while climbing. It never fires on the descent.
- R4: Register addresses on `wr_addr`: 0 is the duty compare, 1 the event compare, 2 the phase offset and 3 the control word. Compare writes go to the shadow copy, and the active copy used by R2 and R3 changes only at a load event.
- R5: Bit 0 of the control word selects the load event: 0 means count at zero and 1 means count at PERIOD. Its value after reset is 0. Writes to the control word take effect at once.
- R6: A phase write of p is applied once, at the next load event. At zero the next count is 1+p, still climbing. At the peak the next count is PERIOD-1-p, still falling. Later periods run normally until another phase write.
- R7: A phase value above PERIOD-2 is stored as PERIOD-2.
- R8: A write in the same cycle as a load event goes to the shadow only. The load transfers the previous shadow value, and the new value becomes active at the following load event.
- R9: During reset `pwm_o`, `irq_o` and `peak_o` are 0 and `zero_o` is 1. After reset the active duty compare is DUTY_RST (300) and the active event compare is EVT_RST (586).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address (R4) |
| wr_data | input | CW | Register write data |
| pwm_o | output | 1 | PWM output |
| irq_o | output | 1 | Event-compare interrupt pulse, climb only |
| zero_o | output | 1 | Count equals zero |
| peak_o | output | 1 | Count equals PERIOD |

## Verification
Assertions check on every cycle that the count stays in range and moves by exactly one step except at a load event. They also check that the active compares hold between load events, that the phase value stays saturated, and that a peak never loads when the zero event is selected. Each PWM edge is checked to follow a compare match in the matching direction. The bench scenarios are needed to show the timing visible at the ports: the shortened period after a phase jump on either event, the duty change landing at the peak instead of at zero, the same-cycle write being deferred by one period, and the absence of interrupts on the descent.

// File: rtl/pwm_updown_pkg.sv
package pwm_updown_pkg;
  typedef enum logic [1:0] {
    REG_DUTY  = 2'd0,
    REG_EVT   = 2'd1,
    REG_PHASE = 2'd2,
    REG_CTRL  = 2'd3
  } reg_addr_e;

  typedef enum logic {
    LOAD_AT_ZERO = 1'b0,
    LOAD_AT_PEAK = 1'b1
  } load_sel_e;
endpackage

// File: rtl/pwm_shadow_regs.sv
module pwm_shadow_regs
  import pwm_updown_pkg::*;
#(
  parameter int CW       = 16,
  parameter int PERIOD   = 600,
  parameter int DUTY_RST = 300,
  parameter int EVT_RST  = 586
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    wr_addr,
  input  logic [CW-1:0] wr_data,
  input  logic          load_evt,
  output logic [CW-1:0] duty_act,
  output logic [CW-1:0] evt_act,
  output logic [CW-1:0] phase_val,
  output logic          phase_pend,
  output load_sel_e     load_sel
);
  localparam logic [CW-1:0] PH_MAX = CW'(PERIOD - 2);

  reg_addr_e     addr;
  logic [CW-1:0] duty_sh, duty_sh_n, evt_sh, evt_sh_n;
  logic [CW-1:0] duty_act_n, evt_act_n, phase_n;
  logic          pend_n, upd_en;
  load_sel_e     sel_n;

  assign addr   = reg_addr_e'(wr_addr);
  assign upd_en = wr_en | load_evt;

  always_comb begin
    duty_sh_n  = duty_sh;
    evt_sh_n   = evt_sh;
    duty_act_n = duty_act;
    evt_act_n  = evt_act;
    phase_n    = phase_val;
    pend_n     = phase_pend;
    sel_n      = load_sel;
    if (load_evt) begin
      duty_act_n = duty_sh;
      evt_act_n  = evt_sh;
      pend_n     = 1'b0;
    end
    if (wr_en) begin
      case (addr)
        REG_DUTY:  duty_sh_n = wr_data;
        REG_EVT:   evt_sh_n  = wr_data;
        REG_PHASE: begin
          phase_n = (wr_data > PH_MAX) ? PH_MAX : wr_data;
          pend_n  = 1'b1;
        end
        default:   sel_n = load_sel_e'(wr_data[0]);
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      duty_sh    <= CW'(DUTY_RST);
      evt_sh     <= CW'(EVT_RST);
      duty_act   <= CW'(DUTY_RST);
      evt_act    <= CW'(EVT_RST);
      phase_val  <= '0;
      phase_pend <= 1'b0;
      load_sel   <= LOAD_AT_ZERO;
    end else if (upd_en) begin
      duty_sh    <= duty_sh_n;
      evt_sh     <= evt_sh_n;
      duty_act   <= duty_act_n;
      evt_act    <= evt_act_n;
      phase_val  <= phase_n;
      phase_pend <= pend_n;
      load_sel   <= sel_n;
    end
  end

  assert_act_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !load_evt |=> ($stable(duty_act) && $stable(evt_act)));

  assert_phase_sat_R7: assert property (@(posedge clk) disable iff (!rst_n)
    phase_val <= PH_MAX);

  assert_same_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (load_evt && wr_en && addr == REG_DUTY) |=> (duty_act == $past(duty_sh)));
endmodule

// File: rtl/pwm_counter.sv
module pwm_counter
  import pwm_updown_pkg::*;
#(
  parameter int CW     = 16,
  parameter int PERIOD = 600
) (
  input  logic          clk,
  input  logic          rst_n,
  input  load_sel_e     load_sel,
  input  logic [CW-1:0] phase_val,
  input  logic          phase_pend,
  output logic [CW-1:0] cnt,
  output logic          dir_up,
  output logic          at_zero,
  output logic          at_peak,
  output logic          load_evt
);
  localparam logic [CW-1:0] TOP = CW'(PERIOD);
  localparam logic [CW-1:0] ONE = CW'(1);

  logic [CW-1:0] cnt_n;
  logic          dir_n;

  assign at_zero  = (cnt == '0);
  assign at_peak  = (cnt == TOP);
  assign load_evt = (load_sel == LOAD_AT_PEAK) ? at_peak : at_zero;

  always_comb begin
    cnt_n = cnt;
    dir_n = dir_up;
    if (load_evt && phase_pend) begin
      cnt_n = at_zero ? (ONE + phase_val) : (TOP - ONE - phase_val);
    end else if (dir_up) begin
      if (cnt >= TOP - ONE) begin
        cnt_n = TOP;
        dir_n = 1'b0;
      end else begin
        cnt_n = cnt + ONE;
      end
    end else begin
      if (cnt <= ONE) begin
        cnt_n = '0;
        dir_n = 1'b1;
      end else begin
        cnt_n = cnt - ONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      dir_up <= 1'b1;
    end else begin
      cnt    <= cnt_n;
      dir_up <= dir_n;
    end
  end

  assert_cnt_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= TOP);

  assert_unit_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !load_evt |=> (cnt == $past(cnt) + ONE || cnt == $past(cnt) - ONE));

  assert_turn_dir_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (at_peak |-> !dir_up) and (at_zero |-> dir_up));
endmodule

// File: rtl/pwm_outgen.sv
module pwm_outgen #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] cnt,
  input  logic          dir_up,
  input  logic [CW-1:0] duty_act,
  input  logic [CW-1:0] evt_act,
  output logic          pwm_o,
  output logic          irq_o
);
  logic duty_hit, pwm_n;

  assign duty_hit = (cnt == duty_act);
  assign irq_o    = dir_up && (cnt == evt_act);

  always_comb begin
    pwm_n = pwm_o;
    if (duty_hit) pwm_n = dir_up;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pwm_o <= 1'b0;
    else        pwm_o <= pwm_n;
  end

  assert_pwm_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwm_o) |-> $past(dir_up && cnt == duty_act));

  assert_pwm_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pwm_o) |-> $past(!dir_up && cnt == duty_act));
endmodule

// File: rtl/pwm_updown.sv
module pwm_updown
  import pwm_updown_pkg::*;
#(
  parameter int CW       = 16,
  parameter int PERIOD   = 600,
  parameter int DUTY_RST = 300,
  parameter int EVT_RST  = 586
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    wr_addr,
  input  logic [CW-1:0] wr_data,
  output logic          pwm_o,
  output logic          irq_o,
  output logic          zero_o,
  output logic          peak_o
);
  logic [1:0]    rst_sync;
  logic          rst_int_n;
  logic [CW-1:0] cnt, duty_act, evt_act, phase_val;
  logic          dir_up, phase_pend, load_evt;
  load_sel_e     load_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  pwm_shadow_regs #(.CW(CW), .PERIOD(PERIOD), .DUTY_RST(DUTY_RST), .EVT_RST(EVT_RST)) u_regs (
    .clk(clk), .rst_n(rst_int_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .load_evt(load_evt), .duty_act(duty_act), .evt_act(evt_act), .phase_val(phase_val),
    .phase_pend(phase_pend), .load_sel(load_sel)
  );

  pwm_counter #(.CW(CW), .PERIOD(PERIOD)) u_cnt (
    .clk(clk), .rst_n(rst_int_n), .load_sel(load_sel), .phase_val(phase_val),
    .phase_pend(phase_pend), .cnt(cnt), .dir_up(dir_up), .at_zero(zero_o),
    .at_peak(peak_o), .load_evt(load_evt)
  );

  pwm_outgen #(.CW(CW)) u_out (
    .clk(clk), .rst_n(rst_int_n), .cnt(cnt), .dir_up(dir_up), .duty_act(duty_act),
    .evt_act(evt_act), .pwm_o(pwm_o), .irq_o(irq_o)
  );

  assert_sel_zero_R5: assert property (@(posedge clk) disable iff (!rst_int_n)
    (load_sel == LOAD_AT_ZERO && peak_o) |=> ($stable(duty_act) && $stable(evt_act)));
endmodule

// File: tb/tb_pwm_updown.sv
module tb_pwm_updown;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 16;
  localparam int P  = 600;
  localparam int K_ZERO = 0, K_PEAK = 1, K_IRQ = 2, K_RISE = 3, K_FALL = 4;

  typedef struct {
    int    kind;
    int    ofs;
    string tag;
  } item_t;

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [1:0] wr_addr = 2'd0;
  logic [CW-1:0] wr_data = '0;
  logic pwm_o, irq_o, zero_o, peak_o;

  item_t exp_q[$];
  int checks = 0, fails = 0;
  int since = 0;
  bit mon_en = 1'b0;
  logic pwm_prev = 1'b0;

  pwm_updown #(.CW(CW), .PERIOD(P)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .pwm_o(pwm_o), .irq_o(irq_o), .zero_o(zero_o), .peak_o(peak_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic string kname(int k);
    case (k)
      K_ZERO: return "zero/length";
      K_PEAK: return "peak";
      K_IRQ:  return "irq";
      K_RISE: return "pwm-rise";
      default: return "pwm-fall";
    endcase
  endfunction

  function automatic void chk(bit ok, string tag, int act, int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
    end
  endfunction

  function automatic void push(int kind, int ofs, string tag);
    item_t it;
    it.kind = kind; it.ofs = ofs; it.tag = tag;
    exp_q.push_back(it);
  endfunction

  function automatic void push_normal(int d, int e, string tag);
    push(K_IRQ,  e,           {tag, " R3"});
    push(K_RISE, d + 1,       {tag, " R2"});
    push(K_PEAK, P,           {tag, " R1"});
    push(K_FALL, 2*P - d + 1, {tag, " R2"});
    push(K_ZERO, 2*P,         {tag, " R1"});
  endfunction

  function automatic void match(int kind, int ofs);
    int idx = -1;
    for (int i = 0; i < exp_q.size(); i++) begin
      if (exp_q[i].kind == kind) begin
        idx = i;
        break;
      end
    end
    checks++;
    if (idx < 0) begin
      fails++;
      $display("FAIL R1/R2/R3 unexpected %s: actual offset %0d expected none", kname(kind), ofs);
    end else begin
      if (exp_q[idx].ofs != ofs) begin
        fails++;
        $display("FAIL %s %s: actual %0d expected %0d", exp_q[idx].tag, kname(kind), ofs, exp_q[idx].ofs);
      end
      exp_q.delete(idx);
    end
  endfunction

  // monitor: offsets counted from the last zero cycle
  always @(negedge clk) begin
    int len;
    len = since + 1;
    if (zero_o) since = 0;
    else        since = since + 1;
    if (mon_en) begin
      if (zero_o) match(K_ZERO, len);
      if (peak_o) match(K_PEAK, since);
      if (irq_o)  match(K_IRQ, since);
      if (pwm_o && !pwm_prev) match(K_RISE, since);
      if (!pwm_o && pwm_prev) match(K_FALL, since);
    end
    pwm_prev = pwm_o;
  end

  task automatic wr(input logic [1:0] a, input logic [CW-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_zero();
    do @(negedge clk); while (!zero_o);
  endtask

  task automatic wait_peak();
    do @(negedge clk); while (!peak_o);
  endtask

  task automatic sync_zero();
    wait_peak();
    wait_zero();
  endtask

  task automatic enable_mon();
    @(posedge clk);
    mon_en = 1'b1;
  endtask

  task automatic drain(string tag);
    int n = 0;
    while (exp_q.size() != 0 && n < 4000) begin
      @(negedge clk);
      n++;
    end
    while (exp_q.size() != 0) begin
      checks++; fails++;
      $display("FAIL %s missing %s: actual none expected offset %0d",
               exp_q[0].tag, kname(exp_q[0].kind), exp_q[0].ofs);
      exp_q.delete(0);
    end
    @(posedge clk);
    mon_en = 1'b0;
    $display("scenario %s done", tag);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    // R9: reset state
    repeat (4) @(negedge clk);
    chk(pwm_o == 1'b0,  "R9 pwm_o in reset",  int'(pwm_o),  0);
    chk(irq_o == 1'b0,  "R9 irq_o in reset",  int'(irq_o),  0);
    chk(peak_o == 1'b0, "R9 peak_o in reset", int'(peak_o), 0);
    chk(zero_o == 1'b1, "R9 zero_o in reset", int'(zero_o), 1);
    rst_n = 1'b1;

    // S1: default compares (R9, R1, R2, R3)
    sync_zero();
    push_normal(300, 586, "S1 R9");
    push_normal(300, 586, "S1 R9");
    enable_mon();
    drain("S1");

    // S2: compare writes mid-period stay in shadow until next zero (R4)
    sync_zero();
    push_normal(300, 586, "S2 R4 old");
    push_normal(100, 50,  "S2 R4 new");
    enable_mon();
    repeat (400) @(negedge clk);
    wr(2'd0, 16'd100);
    wr(2'd1, 16'd50);
    drain("S2");

    // S3: load at peak, duty update lands mid-period (R5)
    wr(2'd3, 16'd1);
    sync_zero();
    push(K_IRQ, 50, "S3 R5"); push(K_RISE, 101, "S3 R5"); push(K_PEAK, P, "S3 R5");
    push(K_FALL, 2*P - 200 + 1, "S3 R5"); push(K_ZERO, 2*P, "S3 R5");
    push_normal(200, 50, "S3 R5 next");
    enable_mon();
    repeat (300) @(negedge clk);
    wr(2'd0, 16'd200);
    drain("S3");

    // S4: phase applied at peak, once (R6)
    sync_zero();
    push(K_IRQ, 50, "S4 R6"); push(K_RISE, 201, "S4 R6"); push(K_PEAK, P, "S4 R6");
    push(K_FALL, 901, "S4 R6"); push(K_ZERO, 1100, "S4 R6");
    push_normal(200, 50, "S4 R6 once");
    enable_mon();
    repeat (300) @(negedge clk);
    wr(2'd2, 16'd100);
    drain("S4");

    // S5: phase applied at zero, once (R6, R5 back to zero)
    wr(2'd3, 16'd0);
    sync_zero();
    push_normal(200, 50, "S5 R5");
    push(K_IRQ, 10, "S5 R6"); push(K_RISE, 161, "S5 R6"); push(K_PEAK, 560, "S5 R6");
    push(K_FALL, 961, "S5 R6"); push(K_ZERO, 1160, "S5 R6");
    push_normal(200, 50, "S5 R6 once");
    enable_mon();
    repeat (300) @(negedge clk);
    wr(2'd2, 16'd40);
    drain("S5");

    // S6: write in the same cycle as the zero load (R8)
    sync_zero();
    wr_en = 1'b1; wr_addr = 2'd0; wr_data = 16'd400;
    push_normal(200, 50, "S6 R8 deferred");
    push_normal(400, 50, "S6 R8 applied");
    enable_mon();
    @(negedge clk);
    wr_en = 1'b0;
    drain("S6");

    // S7: phase saturates to P-2 (R7)
    sync_zero();
    push_normal(400, 50, "S7 R7");
    push(K_PEAK, 2, "S7 R7"); push(K_ZERO, 602, "S7 R7");
    push_normal(400, 50, "S7 R7 after");
    enable_mon();
    repeat (300) @(negedge clk);
    wr(2'd2, 16'd2000);
    drain("S7");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule